// File: doc/BRIEF.md
# Reset and Pushbutton Debounce Sequencer

This block owns a board-level active-low reset line that is open-drain: it can pull the line low, and an external pushbutton can pull the same line low. The block also raises an access-inhibit signal that keeps the host bus out of the part while any reset activity is in progress. Three things start a reset cycle: an internal power-fail indication, a request from the watchdog, and a press of the pushbutton, which the block senses on the line it drives.

All hold times are counted in ticks of a 4096 Hz enable input, and every hold lasts `HOLD_TICKS` ticks (1024 by default, which is 250 ms). When the supply recovers, the block holds reset for one interval. When the oscillator-disable bit is set, it first waits for the oscillator to report ready and then holds for one interval.

A button press is debounced in three steps. The block first pulls the line low itself for one interval. It then lets go of the line and waits for the line to read high, which shows that the button has been released. Finally it pulls the line low for a second interval. Power-fail overrides every other state and restarts the sequence.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_n` is low, `rst_drive_o` and `bus_block_o` are both 1. After `rst_n` rises with power-fail low and the oscillator-disable bit 0, the block holds reset for exactly `HOLD_TICKS` ticks and then releases it.
- R2: The clock edge that samples `pwr_fail_i` high sets `rst_drive_o` and `bus_block_o` to 1, whatever state the block was in. Both stay at 1 while `pwr_fail_i` is high.
- R3: When `pwr_fail_i` falls with `osc_off_i` at 0, `rst_drive_o` stays at 1 for exactly `HOLD_TICKS` rising edges that carry `tick_i` = 1 and then falls to 0. `osc_rdy_i` has no effect in this case.
- R4: When `pwr_fail_i` falls with `osc_off_i` at 1, `rst_drive_o` stays at 1 until `osc_rdy_i` is 1, and then for a further `HOLD_TICKS` ticks.
- R5: In the idle state, a falling edge of the sensed line (`rst_line_i`) makes `rst_drive_o` 1 within three clocks. The line passes through a two-flop synchronizer before edge detection. `rst_drive_o` then stays at 1 for `HOLD_TICKS` ticks.
- R6: After the first pushbutton hold, `rst_drive_o` is 0 and `bus_block_o` stays 1 for as long as the sensed line reads low.
- R7: Once the sensed line reads high after the first pushbutton hold, `rst_drive_o` is 1 for another `HOLD_TICKS` ticks and then the block returns to idle. This holds whether the button was released during the first hold or after it.
- R8: A one-cycle `wdog_req_i` pulse in the idle state starts a single hold of `HOLD_TICKS` ticks. A request in any other state is ignored.
- R9: The line rising back to high after the block's own drive ends does not start a new reset cycle, so `rst_drive_o` stays 0 in idle with no new event.
- R10: `bus_block_o` is 0 only in the idle state. Whenever `rst_drive_o` is 1, `bus_block_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable pulse at 4096 Hz |
| pwr_fail_i | input | 1 | Supply out of tolerance (1 = fail) |
| rst_line_i | input | 1 | Sensed level of the shared reset line (asynchronous) |
| wdog_req_i | input | 1 | Watchdog reset request pulse |
| osc_off_i | input | 1 | Oscillator-disable bit (1 = wait for oscillator on power-up) |
| osc_rdy_i | input | 1 | Oscillator startup done |
| rst_drive_o | output | 1 | 1 = pull the reset line low |
| bus_block_o | output | 1 | 1 = host bus access inhibited |

## Verification
The sequencer is driven through five stimulus patterns:
- a power-fail release with the oscillator bit clear;
- the same release with the oscillator bit set and a delayed ready;
- a watchdog pulse;
- a short press, released during the first hold;
- a long press, held past the first hold.

Each hold is measured in ticks. The short and long presses are what distinguish a correct wait-for-release from a controller that times one hold and returns to idle. The long press is also what shows that the line is released while access remains blocked.

Directed cases cover the reset state and power-fail arriving in the middle of a debounce. They also cover a watchdog pulse during the release wait, which must have no effect, and a quiet interval after each cycle. That quiet interval shows that the block's own release of the line is not taken for a new press.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_PFAIL     = 3'd0,
    ST_OSC_WAIT  = 3'd1,
    ST_PUP_HOLD  = 3'd2,
    ST_IDLE      = 3'd3,
    ST_WDOG_HOLD = 3'd4,
    ST_PB_HOLD   = 3'd5,
    ST_PB_WAIT   = 3'd6,
    ST_PB_REHOLD = 3'd7
  } seq_state_e;

  function automatic logic state_drives(seq_state_e s);
    return (s != ST_IDLE) && (s != ST_PB_WAIT);
  endfunction

  function automatic logic state_times(seq_state_e s);
    return (s == ST_PUP_HOLD) || (s == ST_WDOG_HOLD) ||
           (s == ST_PB_HOLD)  || (s == ST_PB_REHOLD);
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // the chain resets to the idle (released) line level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int HOLD_TICKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done_o = (cnt_q == LIMIT);
  assign cnt_en = !run_i || (tick_i && !done_o);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)
      cnt_d = '0;
    else if (tick_i && !done_o)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R3

  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0); // R3

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  input  logic wdog_req_i,
  input  logic osc_off_i,
  input  logic osc_rdy_i,
  input  logic line_lvl_i,
  input  logic line_fall_i,
  input  logic hold_done_i,
  output logic hold_run_o,
  output logic drive_o,
  output logic block_o
);

  seq_state_e state_q, state_d;
  logic       drive_q, block_q;

  always_comb begin
    state_d = state_q;
    if (pwr_fail_i) begin
      state_d = ST_PFAIL;
    end else begin
      case (state_q)
        ST_PFAIL:     state_d = osc_off_i ? ST_OSC_WAIT : ST_PUP_HOLD;
        ST_OSC_WAIT:  if (osc_rdy_i) state_d = ST_PUP_HOLD;
        ST_PUP_HOLD:  if (hold_done_i) state_d = ST_IDLE;
        ST_IDLE: begin
          if (wdog_req_i)       state_d = ST_WDOG_HOLD;
          else if (line_fall_i) state_d = ST_PB_HOLD;
        end
        ST_WDOG_HOLD: if (hold_done_i) state_d = ST_IDLE;
        ST_PB_HOLD:   if (hold_done_i) state_d = ST_PB_WAIT;
        ST_PB_WAIT:   if (line_lvl_i)  state_d = ST_PB_REHOLD;
        ST_PB_REHOLD: if (hold_done_i) state_d = ST_IDLE;
        default:      state_d = ST_PFAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PFAIL;
      drive_q <= 1'b1;
      block_q <= 1'b1;
    end else begin
      state_q <= state_d;
      drive_q <= state_drives(state_d);
      block_q <= (state_d != ST_IDLE);
    end
  end

  assign hold_run_o = state_times(state_q);
  assign drive_o    = drive_q;
  assign block_o    = block_q;

  AST_PFAIL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> drive_o && block_o); // R2

  AST_DRIVE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> block_o); // R10

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUP_HOLD && !pwr_fail_i && !hold_done_i)
      |=> state_q == ST_PUP_HOLD); // R3

  AST_OSC_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OSC_WAIT && !pwr_fail_i && !osc_rdy_i)
      |=> state_q == ST_OSC_WAIT && drive_o); // R4

  AST_PB_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && line_fall_i && !wdog_req_i && !pwr_fail_i)
      |=> state_q == ST_PB_HOLD && drive_o); // R5

  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PB_WAIT |-> !drive_o && block_o); // R6

  AST_WDOG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && wdog_req_i && !pwr_fail_i)
      |=> state_q == ST_WDOG_HOLD); // R8

  AST_WDOG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PB_WAIT && wdog_req_i && !pwr_fail_i && !line_lvl_i)
      |=> state_q == ST_PB_WAIT); // R8

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int HOLD_TICKS  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pwr_fail_i,
  input  logic rst_line_i,
  input  logic wdog_req_i,
  input  logic osc_off_i,
  input  logic osc_rdy_i,
  output logic rst_drive_o,
  output logic bus_block_o
);

  logic line_lvl, line_fall, hold_run, hold_done;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (rst_line_i),
    .level_o (line_lvl),
    .fall_o  (line_fall)
  );

  rstseq_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (hold_run),
    .tick_i (tick_i),
    .done_o (hold_done)
  );

  rstseq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_fail_i  (pwr_fail_i),
    .wdog_req_i  (wdog_req_i),
    .osc_off_i   (osc_off_i),
    .osc_rdy_i   (osc_rdy_i),
    .line_lvl_i  (line_lvl),
    .line_fall_i (line_fall),
    .hold_done_i (hold_done),
    .hold_run_o  (hold_run),
    .drive_o     (rst_drive_o),
    .block_o     (bus_block_o)
  );

endmodule

// File: tb/tb_rstseq_top.sv
`timescale 1ns/1ps
module tb_rstseq_top;

  localparam int HOLD = 5;
  localparam int TDIV = 16;

  // vector: kind[3:0], expected ticks per hold[7:0]
  // kind 0 = power-fail release, 1 = watchdog, 2 = short press,
  // 3 = long press, 4 = power-fail release waiting for oscillator
  localparam logic [11:0] VEC [5] = '{
    {4'd0, 8'(HOLD)}, {4'd1, 8'(HOLD)}, {4'd2, 8'(HOLD)},
    {4'd3, 8'(HOLD)}, {4'd4, 8'(HOLD)}
  };

  logic clk = 1'b0;
  logic rst_n, tick, pfail, wdog, osc_off, osc_rdy, btn;
  logic drv, blk, line;
  int   checks = 0, errors = 0, tdiv = 0;

  always #2 clk = ~clk;

  assign line = ~(drv | btn);

  rstseq_top #(.HOLD_TICKS(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pwr_fail_i(pfail),
    .rst_line_i(line), .wdog_req_i(wdog), .osc_off_i(osc_off),
    .osc_rdy_i(osc_rdy), .rst_drive_o(drv), .bus_block_o(blk)
  );

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tdiv = (tdiv + 1) % TDIV;
      tick = (tdiv == 0);
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic align();
    do @(negedge clk); while (tick !== 1'b1);
    @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (drv !== 1'b1) break;
      if (tick) n++;
    end
  endtask

  task automatic wait_drive(output int ok);
    ok = 0;
    for (int g = 0; g < 8; g++) begin
      @(negedge clk);
      if (drv === 1'b1) begin ok = 1; break; end
    end
  endtask

  task automatic quiet(string tag);
    int hit = 0;
    for (int g = 0; g < 3 * TDIV; g++) begin
      @(negedge clk);
      if (drv !== 1'b0 || blk !== 1'b0) hit = 1;
    end
    chk(tag, hit, 0);
  endtask

  task automatic run_case(int kind, int exp);
    int n, ok;
    case (kind)
      0: begin
        osc_off = 1'b0; osc_rdy = 1'b0;
        align(); pfail = 1'b1;
        @(negedge clk); chk("R2 drive on power-fail", drv, 1);
        align(); pfail = 1'b0;
        measure(n); chk("R3 power-up hold ticks", n, exp);
        quiet("R9 quiet after power-up hold");
      end
      1: begin
        align(); wdog = 1'b1; @(negedge clk); wdog = 1'b0;
        chk("R8 watchdog drives", drv, 1);
        measure(n); chk("R8 watchdog hold ticks", n, exp);
        quiet("R9 quiet after watchdog hold");
      end
      2: begin
        align(); btn = 1'b1;
        wait_drive(ok); chk("R5 press drives", ok, 1);
        repeat (4) @(negedge clk);
        btn = 1'b0;
        measure(n); chk("R5 first hold ticks (short)", n, exp);
        wait_drive(ok); chk("R7 rehold starts (short)", ok, 1);
        measure(n); chk("R7 second hold ticks (short)", n, exp);
        quiet("R9 quiet after short press");
      end
      3: begin
        align(); btn = 1'b1;
        wait_drive(ok); chk("R5 press drives (long)", ok, 1);
        measure(n); chk("R5 first hold ticks (long)", n, exp);
        repeat (2 * TDIV) @(negedge clk);
        chk("R6 line released while held", drv, 0);
        chk("R6 access blocked while held", blk, 1);
        wdog = 1'b1; @(negedge clk); wdog = 1'b0;
        repeat (TDIV) @(negedge clk);
        chk("R8 watchdog ignored in wait", drv, 0);
        align(); btn = 1'b0;
        wait_drive(ok); chk("R7 rehold starts (long)", ok, 1);
        measure(n); chk("R7 second hold ticks (long)", n, exp);
        chk("R10 block clear after cycle", blk, 0);
        quiet("R9 quiet after long press");
      end
      default: begin
        osc_off = 1'b1; osc_rdy = 1'b0;
        align(); pfail = 1'b1;
        repeat (3) @(negedge clk);
        pfail = 1'b0;
        repeat (4 * TDIV) @(negedge clk);
        chk("R4 held while oscillator not ready", drv, 1);
        align(); osc_rdy = 1'b1;
        measure(n); chk("R4 hold after oscillator ready", n, exp);
        osc_off = 1'b0;
        quiet("R9 quiet after oscillator hold");
      end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, ok;
    rst_n = 1'b0; pfail = 1'b0; wdog = 1'b0; osc_off = 1'b0;
    osc_rdy = 1'b0; btn = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset drive", drv, 1);
    chk("R1 reset block", blk, 1);
    align(); rst_n = 1'b1;
    measure(n); chk("R1 hold after reset", n, HOLD);
    chk("R10 block clear in idle", blk, 0);
    quiet("R9 quiet after reset");

    foreach (VEC[i]) run_case(int'(VEC[i][11:8]), int'(VEC[i][7:0]));

    // power-fail arriving in the middle of a debounce restarts the hold
    align(); btn = 1'b1;
    wait_drive(ok);
    repeat (20) @(negedge clk);
    pfail = 1'b1; btn = 1'b0;
    @(negedge clk);
    chk("R2 power-fail during debounce", drv, 1);
    repeat (3 * TDIV) @(negedge clk);
    chk("R2 still driven under power-fail", drv, 1);
    chk("R10 still blocked under power-fail", blk, 1);
    align(); pfail = 1'b0;
    measure(n); chk("R3 hold restarts after power-fail", n, HOLD);
    quiet("R9 quiet after power-fail priority");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule